// File: doc/BRIEF.md
# Two-Channel Bus Break Comparator

This block watches a processor-side bus and asks for a debug break when an access matches conditions set up by software. There are two channels, A and B. Each channel compares the bus address against a base address. Address bits set in the channel's mask are left out of the comparison. Each channel also compares an 8-bit address-space identifier and three bus-cycle qualifiers: which master drives the cycle (CPU or DMA), whether it is an instruction fetch or a data access, and whether it is a read or a write. Channel B can also compare the bus data under a data mask.

Every qualifier is a 2-bit selector, and a selector of 00 turns its channel off. A match sets a sticky flag for that channel and master. Only software can clear a flag, by writing 0 to it. Hits from both channels are merged into one break request pulse, which carries a break-type code. A hit that lands within a programmable holdoff window after a request is folded into that request. A near-simultaneous data break and fetch break therefore give one request, while both channels' flags are still set.

Top module: `bus_break_cmp`

## Requirements
- R1: A channel matches only when the bus address and the base address agree on every bit that is clear in the channel's address mask. Bits set in the mask are ignored.
- R2: On a CPU cycle (bus_dma=0) a channel matches only if bus_id equals the channel's identifier register. On a DMA cycle (bus_dma=1) the identifier is not compared.
- R3: Channel B also requires bus_data to equal its data register on every bit that is clear in its data mask. Channel A never compares data.
- R4: The qualifier field of each condition register uses these bit positions: [1:0] master, [3:2] access kind, [5:4] direction. For master, 01 selects CPU, 10 selects DMA and 11 selects either. For access kind, 01 selects fetch, 10 selects data access and 11 selects either. For direction, 01 selects read, 10 selects write and 11 selects either. If any of the three fields is 00, the channel never matches.
- R5: A match sets a sticky flag. The flags register uses these bit positions: bit 0 is channel A CPU, bit 1 is channel A DMA, bit 2 is channel B CPU and bit 3 is channel B DMA. The flag is set on the clock edge that samples the matching access.
- R6: Writing 0 to a flag bit clears it. Writing 1 has no effect. A flag that is set stays set until software clears it. A match in the same cycle as a clear leaves the flag set.
- R7: Consider a match sampled at a clock edge when no holdoff window is open. brk_req is high for the following cycle, and brk_type is 01 for a fetch or 10 for a data access. When brk_req is low, brk_type is 00. With a nonzero holdoff, brk_req is never high for two cycles in a row.
- R8: Let the holdoff register hold H. After a request, matches at the next H sampling edges raise no request, but they still set their flags. The first match after those edges raises a new request.
- R9: Reset clears the condition registers, the flags, the masks, the base address, the data register and brk_req, and sets the holdoff register to 2. Reset leaves both identifier registers unchanged.
- R10: The register indices on reg_addr are as follows. Channel A uses 0 (address), 1 (address mask), 2 (identifier) and 3 (condition). Channel B uses 4, 5, 6 and 7 in the same order. Index 8 is channel B data, 9 is channel B data mask, 10 is flags and 11 is holdoff. Reads are combinational and zero-extended, and unused indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data (combinational) |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_addr | input | ADDR_W | Access address |
| bus_id | input | 8 | Address-space identifier of the access |
| bus_dma | input | 1 | 1 = DMA cycle, 0 = CPU cycle |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_data | input | DATA_W | Access data |
| brk_req | output | 1 | One-cycle break request |
| brk_type | output | 2 | 01 fetch, 10 data, 00 idle |

## Verification
The bench builds the block with its default values: 32-bit address, data and register words, a 4-bit holdoff field and a reset holdoff of 2. Because the reset value is 2, the bench can see the reset default of the holdoff register. The 4-bit field lets the bench program 0, so that each hit raises its own request, and 3, so that it can place a hit exactly on the last suppressed edge and the next one on the first edge that raises a request again. The full-width masks make it possible to test partial address masking and a data compare limited to one byte lane.

// File: rtl/bbc_pkg.sv
// Shared definitions for the two-channel bus break comparator.
// Assumes exactly two channels; channel index NCH-1 carries the data compare.
package bbc_pkg;
    localparam int ID_W      = 8;
    localparam int NCH       = 2;
    localparam int NFLAG     = 2 * NCH;
    localparam int REG_AW    = 4;
    localparam int CH_STRIDE = 4;

    // Per-channel register offsets inside a channel's stride
    localparam int OFS_ADDR  = 0;
    localparam int OFS_AMASK = 1;
    localparam int OFS_ID    = 2;
    localparam int OFS_QUAL  = 3;

    // Shared register indices
    localparam logic [REG_AW-1:0] RI_DATA  = 4'd8;
    localparam logic [REG_AW-1:0] RI_DMASK = 4'd9;
    localparam logic [REG_AW-1:0] RI_FLAGS = 4'd10;
    localparam logic [REG_AW-1:0] RI_HOLD  = 4'd11;

    // Qualifier field: [5:4] direction, [3:2] access kind, [1:0] master
    typedef struct packed {
        logic [1:0] dir;
        logic [1:0] kind;
        logic [1:0] master;
    } qual_t;

    typedef enum logic [1:0] {
        BT_NONE  = 2'b00,
        BT_FETCH = 2'b01,
        BT_DATA  = 2'b10
    } brk_type_e;

    // Selector decode: 01 first option, 10 second option, 11 either, 00 never
    function automatic logic sel_ok(input logic [1:0] sel, input logic second);
        case (sel)
            2'b01:   return !second;
            2'b10:   return second;
            2'b11:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/bbc_chan.sv
// One break channel comparator: masked address, identifier (CPU cycles only),
// three 2-bit qualifiers and, when HAS_DATA is set, masked data.
// Purely combinational; assumes configuration is stable while compared.
module bbc_chan
    import bbc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter bit HAS_DATA = 1'b0
)(
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ID_W-1:0]   bus_id,
    input  logic              bus_dma,
    input  logic              bus_fetch,
    input  logic              bus_write,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_amask,
    input  logic [ID_W-1:0]   cfg_id,
    input  qual_t             cfg_qual,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic [DATA_W-1:0] cfg_dmask,
    output logic              hit
);
    logic addr_ok;
    logic id_ok;
    logic qual_ok;
    logic data_ok;

    // Evaluate each compare term and combine them into the channel hit
    always_comb begin
        addr_ok = ((bus_addr ^ cfg_addr) & ~cfg_amask) == '0;
        id_ok   = bus_dma || (bus_id == cfg_id);
        qual_ok = sel_ok(cfg_qual.master, bus_dma)
               && sel_ok(cfg_qual.kind, !bus_fetch)
               && sel_ok(cfg_qual.dir, bus_write);
        data_ok = !HAS_DATA || (((bus_data ^ cfg_data) & ~cfg_dmask) == '0);
        hit     = bus_valid && addr_ok && id_ok && qual_ok && data_ok;
    end
endmodule

// File: rtl/bbc_regs.sv
// Register file: channel configuration, channel B data compare, sticky flags
// and the holdoff window. Identifier registers are deliberately not reset.
// Assumes REG_W is at least ADDR_W and DATA_W.
module bbc_regs
    import bbc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int REG_W    = 32,
    parameter int HOLD_W   = 4,
    parameter int HOLD_RST = 2
)(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic [REG_AW-1:0]             reg_addr,
    input  logic [REG_W-1:0]              reg_wdata,
    output logic [REG_W-1:0]              reg_rdata,
    input  logic [NFLAG-1:0]              flag_set,
    output logic [NCH-1:0][ADDR_W-1:0]    cfg_addr,
    output logic [NCH-1:0][ADDR_W-1:0]    cfg_amask,
    output logic [NCH-1:0][ID_W-1:0]      cfg_id,
    output qual_t [NCH-1:0]               cfg_qual,
    output logic [DATA_W-1:0]             cfg_data,
    output logic [DATA_W-1:0]             cfg_dmask,
    output logic [NFLAG-1:0]              flag_q,
    output logic [HOLD_W-1:0]             hold_cfg
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        localparam logic [REG_AW-1:0] I_ADDR  = REG_AW'(ch * CH_STRIDE + OFS_ADDR);
        localparam logic [REG_AW-1:0] I_AMASK = REG_AW'(ch * CH_STRIDE + OFS_AMASK);
        localparam logic [REG_AW-1:0] I_ID    = REG_AW'(ch * CH_STRIDE + OFS_ID);
        localparam logic [REG_AW-1:0] I_QUAL  = REG_AW'(ch * CH_STRIDE + OFS_QUAL);

        // Reset-cleared channel configuration written by software
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_addr[ch]  <= '0;
                cfg_amask[ch] <= '0;
                cfg_qual[ch]  <= '0;
            end else if (reg_wr) begin
                if (reg_addr == I_ADDR)  cfg_addr[ch]  <= reg_wdata[ADDR_W-1:0];
                if (reg_addr == I_AMASK) cfg_amask[ch] <= reg_wdata[ADDR_W-1:0];
                if (reg_addr == I_QUAL)  cfg_qual[ch]  <= reg_wdata[$bits(qual_t)-1:0];
            end
        end

        // Identifier register keeps its value across reset
        always_ff @(posedge clk) begin
            if (reg_wr && reg_addr == I_ID) cfg_id[ch] <= reg_wdata[ID_W-1:0];
        end
    end

    // Shared data compare, holdoff and sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_data  <= '0;
            cfg_dmask <= '0;
            hold_cfg  <= HOLD_W'(HOLD_RST);
            flag_q    <= '0;
        end else begin
            if (reg_wr && reg_addr == RI_DATA)  cfg_data  <= reg_wdata[DATA_W-1:0];
            if (reg_wr && reg_addr == RI_DMASK) cfg_dmask <= reg_wdata[DATA_W-1:0];
            if (reg_wr && reg_addr == RI_HOLD)  hold_cfg  <= reg_wdata[HOLD_W-1:0];
            if (reg_wr && reg_addr == RI_FLAGS)
                flag_q <= (flag_q & reg_wdata[NFLAG-1:0]) | flag_set;
            else
                flag_q <= flag_q | flag_set;
        end
    end

    // Combinational zero-extended read mux
    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (reg_addr == REG_AW'(c * CH_STRIDE + OFS_ADDR))  reg_rdata = REG_W'(cfg_addr[c]);
            if (reg_addr == REG_AW'(c * CH_STRIDE + OFS_AMASK)) reg_rdata = REG_W'(cfg_amask[c]);
            if (reg_addr == REG_AW'(c * CH_STRIDE + OFS_ID))    reg_rdata = REG_W'(cfg_id[c]);
            if (reg_addr == REG_AW'(c * CH_STRIDE + OFS_QUAL))  reg_rdata = REG_W'(cfg_qual[c]);
        end
        case (reg_addr)
            RI_DATA:  reg_rdata = REG_W'(cfg_data);
            RI_DMASK: reg_rdata = REG_W'(cfg_dmask);
            RI_FLAGS: reg_rdata = REG_W'(flag_q);
            RI_HOLD:  reg_rdata = REG_W'(hold_cfg);
            default:  ;
        endcase
    end
endmodule

// File: rtl/bbc_merge.sv
// Merges channel hits into one registered break request pulse with a type
// code. A holdoff down-counter folds later hits into the same request.
// Assumes hits are presented in the cycle of the matching access.
module bbc_merge
    import bbc_pkg::*;
#(
    parameter int NHIT   = 2,
    parameter int HOLD_W = 4
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NHIT-1:0]   hit,
    input  logic              bus_fetch,
    input  logic [HOLD_W-1:0] hold_cfg,
    output logic              brk_req,
    output logic [1:0]        brk_type
);
    logic [HOLD_W-1:0] cnt_q;
    brk_type_e         type_q;

    // Issue a pulse on a hit outside the window and run the holdoff counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_req <= 1'b0;
            type_q  <= BT_NONE;
            cnt_q   <= '0;
        end else begin
            brk_req <= 1'b0;
            type_q  <= BT_NONE;
            if (|hit && cnt_q == '0) begin
                brk_req <= 1'b1;
                type_q  <= bus_fetch ? BT_FETCH : BT_DATA;
                cnt_q   <= hold_cfg;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - HOLD_W'(1);
            end
        end
    end

    assign brk_type = type_q;
endmodule

// File: rtl/bus_break_cmp.sv
// Two-channel bus break comparator top: register file, one comparator per
// channel (the last one with data compare) and the request merge.
// Assumes a synchronous active-low reset and one bus access per cycle.
module bus_break_cmp
    import bbc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int REG_W    = 32,
    parameter int HOLD_W   = 4,
    parameter int HOLD_RST = 2
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ID_W-1:0]   bus_id,
    input  logic              bus_dma,
    input  logic              bus_fetch,
    input  logic              bus_write,
    input  logic [DATA_W-1:0] bus_data,
    output logic              brk_req,
    output logic [1:0]        brk_type
);
    logic [NCH-1:0][ADDR_W-1:0] cfg_addr;
    logic [NCH-1:0][ADDR_W-1:0] cfg_amask;
    logic [NCH-1:0][ID_W-1:0]   cfg_id;
    qual_t [NCH-1:0]            cfg_qual;
    logic [DATA_W-1:0]          cfg_data;
    logic [DATA_W-1:0]          cfg_dmask;
    logic [NFLAG-1:0]           flag_q;
    logic [NFLAG-1:0]           flag_set;
    logic [HOLD_W-1:0]          hold_cfg;
    logic [NCH-1:0]             ch_hit;

    bbc_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W),
        .HOLD_W(HOLD_W), .HOLD_RST(HOLD_RST)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .flag_set(flag_set),
        .cfg_addr(cfg_addr), .cfg_amask(cfg_amask), .cfg_id(cfg_id), .cfg_qual(cfg_qual),
        .cfg_data(cfg_data), .cfg_dmask(cfg_dmask),
        .flag_q(flag_q), .hold_cfg(hold_cfg)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        localparam bit HAS = (ch == NCH - 1);
        logic [DATA_W-1:0] d_cfg;
        logic [DATA_W-1:0] m_cfg;

        // Only the data-capable channel sees the data compare registers
        assign d_cfg = HAS ? cfg_data  : '0;
        assign m_cfg = HAS ? cfg_dmask : '0;

        bbc_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HAS_DATA(HAS)) chan_i (
            .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_id(bus_id),
            .bus_dma(bus_dma), .bus_fetch(bus_fetch), .bus_write(bus_write),
            .bus_data(bus_data),
            .cfg_addr(cfg_addr[ch]), .cfg_amask(cfg_amask[ch]), .cfg_id(cfg_id[ch]),
            .cfg_qual(cfg_qual[ch]), .cfg_data(d_cfg), .cfg_dmask(m_cfg),
            .hit(ch_hit[ch])
        );

        // Route the hit to the CPU or DMA flag of this channel
        assign flag_set[2*ch]     = ch_hit[ch] && !bus_dma;
        assign flag_set[2*ch + 1] = ch_hit[ch] &&  bus_dma;
    end

    bbc_merge #(.NHIT(NCH), .HOLD_W(HOLD_W)) merge_i (
        .clk(clk), .rst_n(rst_n), .hit(ch_hit), .bus_fetch(bus_fetch),
        .hold_cfg(hold_cfg), .brk_req(brk_req), .brk_type(brk_type)
    );
endmodule

// File: rtl/bbc_checker.sv
// Property checker for the bus break comparator, attached by bind.
// Assumes the top-level internal names ch_hit, cfg_qual, cfg_id, flag_q, hold_cfg.
module bbc_checker
    import bbc_pkg::*;
#(
    parameter int HOLD_W = 4
)(
    input logic              clk,
    input logic              rst_n,
    input logic [NCH-1:0]    ch_hit,
    input qual_t [NCH-1:0]   cfg_qual,
    input logic [NCH-1:0][ID_W-1:0] cfg_id,
    input logic [ID_W-1:0]   bus_id,
    input logic              bus_dma,
    input logic [NFLAG-1:0]  flag_q,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [NFLAG-1:0]  wr_bits,
    input logic [HOLD_W-1:0] hold_cfg,
    input logic              brk_req,
    input logic [1:0]        brk_type
);
    // A channel with any 00 qualifier never hits
    p_disabled_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_qual[0].master == 2'b00 || cfg_qual[0].kind == 2'b00 || cfg_qual[0].dir == 2'b00)
        |-> !ch_hit[0]);
    p_disabled_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_qual[1].master == 2'b00 || cfg_qual[1].kind == 2'b00 || cfg_qual[1].dir == 2'b00)
        |-> !ch_hit[1]);

    // CPU-cycle hits require the identifier to agree
    p_id_cpu_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_hit[0] && !bus_dma) |-> (bus_id == cfg_id[0]));

    // Hits set the matching master flag on the next edge
    p_flag_set_a_cpu_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_hit[0] && !bus_dma) |=> flag_q[0]);
    p_flag_set_b_dma_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_hit[1] && bus_dma) |=> flag_q[3]);

    // A set flag survives anything but a write of 0 to it
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[2] && !(reg_wr && reg_addr == RI_FLAGS && !wr_bits[2])) |=> flag_q[2]);

    // Requests are caused by a hit and carry a legal type
    p_req_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> $past(|ch_hit));
    p_req_type_r7: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> (brk_type == 2'b01 || brk_type == 2'b10));
    p_idle_type_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !brk_req |-> (brk_type == 2'b00));
    p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && hold_cfg != '0) |=> !brk_req);
endmodule

bind bus_break_cmp bbc_checker #(.HOLD_W(HOLD_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .ch_hit(ch_hit), .cfg_qual(cfg_qual), .cfg_id(cfg_id),
    .bus_id(bus_id), .bus_dma(bus_dma), .flag_q(flag_q), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .wr_bits(reg_wdata[bbc_pkg::NFLAG-1:0]), .hold_cfg(hold_cfg),
    .brk_req(brk_req), .brk_type(brk_type)
);

// File: tb/bus_break_cmp_tb_top.sv
// Scoreboard bench: access tasks queue the expected request/type for the
// cycle after each access; a monitor pops and compares on falling edges.
module bus_break_cmp_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [7:0]  bus_id = '0;
    logic        bus_dma = 1'b0;
    logic        bus_fetch = 1'b0;
    logic        bus_write = 1'b0;
    logic [31:0] bus_data = '0;
    logic        brk_req;
    logic [1:0]  brk_type;

    int checks = 0;
    int errors = 0;
    logic [2:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_break_cmp dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
        .bus_addr(bus_addr), .bus_id(bus_id), .bus_dma(bus_dma), .bus_fetch(bus_fetch),
        .bus_write(bus_write), .bus_data(bus_data), .brk_req(brk_req), .brk_type(brk_type)
    );

    // Monitor: compare queued expectations, otherwise no request may appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (exp_q.size() > 0) begin
                logic [2:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if ({brk_req, brk_type} !== e) begin
                    errors++;
                    $display("FAIL %s: req/type got %b/%b expected %b/%b",
                             t, brk_req, brk_type, e[2], e[1:0]);
                end
            end else if (brk_req !== 1'b0) begin
                errors++;
                $display("FAIL R7: request got 1 expected 0 with no access pending");
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b0; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_valid = 1'b0; reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s: reg %0d got %h expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic access(input logic dma, input logic fetch, input logic write,
                          input logic [31:0] addr, input logic [7:0] id,
                          input logic [31:0] data, input logic ereq,
                          input logic [1:0] etyp, input string tag);
        @(negedge clk);
        bus_valid = 1'b1; bus_dma = dma; bus_fetch = fetch; bus_write = write;
        bus_addr = addr; bus_id = id; bus_data = data;
        @(posedge clk);
        #1;
        exp_q.push_back({ereq, etyp});
        tag_q.push_back(tag);
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Stimulus
    initial begin
        do_reset();
        // R9: identifiers survive reset, other state is cleared
        wr(4'd2, 32'h5A);
        wr(4'd6, 32'hC3);
        wr(4'd3, 32'h3F);
        wr(4'd11, 32'h7);
        do_reset();
        rd_chk(4'd2,  32'h5A, "R9 id A kept");
        rd_chk(4'd6,  32'hC3, "R9 id B kept");
        rd_chk(4'd3,  32'h0,  "R9 cond A cleared");
        rd_chk(4'd10, 32'h0,  "R9 flags cleared");
        rd_chk(4'd11, 32'h2,  "R10 holdoff default");
        rd_chk(4'd12, 32'h0,  "R10 unused index");

        // Channel A: data accesses, either master, either direction
        wr(4'd11, 32'h0);
        wr(4'd0, 32'h1000_0040);
        wr(4'd1, 32'h0000_000F);
        wr(4'd3, 32'h3B);
        rd_chk(4'd1, 32'h0000_000F, "R10 mask A readback");
        access(0, 0, 0, 32'h1000_0047, 8'h5A, 32'h0, 1'b1, 2'b10, "R1 masked address hit");
        rd_chk(4'd10, 32'h1, "R5 A cpu flag");
        access(0, 0, 0, 32'h1000_0050, 8'h5A, 32'h0, 1'b0, 2'b00, "R1 unmasked bit differs");
        access(0, 0, 1, 32'h1000_0040, 8'h11, 32'h0, 1'b0, 2'b00, "R2 cpu id mismatch");
        access(1, 0, 1, 32'h1000_0040, 8'h11, 32'h0, 1'b1, 2'b10, "R2 dma ignores id");
        rd_chk(4'd10, 32'h3, "R5 A dma flag");
        access(0, 1, 0, 32'h1000_0040, 8'h5A, 32'h0, 1'b0, 2'b00, "R4 fetch filtered");
        wr(4'd10, 32'h2);
        rd_chk(4'd10, 32'h2, "R6 clear by zero");
        wr(4'd10, 32'hF);
        rd_chk(4'd10, 32'h2, "R6 one has no effect");
        wr(4'd10, 32'h0);
        wr(4'd3, 32'h0B);
        access(0, 0, 0, 32'h1000_0040, 8'h5A, 32'h0, 1'b0, 2'b00, "R4 zero direction disables");
        rd_chk(4'd10, 32'h0, "R4 no flag when disabled");

        // Channel B: CPU only, fetch or data, writes only, byte-lane data compare
        wr(4'd4, 32'h2000_0000);
        wr(4'd5, 32'h0);
        wr(4'd7, 32'h2D);
        wr(4'd8, 32'h0000_AB00);
        wr(4'd9, 32'hFFFF_00FF);
        access(0, 0, 1, 32'h2000_0000, 8'hC3, 32'h1234_AB77, 1'b1, 2'b10, "R3 masked data hit");
        rd_chk(4'd10, 32'h4, "R5 B cpu flag");
        access(0, 0, 1, 32'h2000_0000, 8'hC3, 32'h1234_AC77, 1'b0, 2'b00, "R3 data lane differs");
        access(0, 0, 0, 32'h2000_0000, 8'hC3, 32'h0000_AB00, 1'b0, 2'b00, "R4 read filtered");
        access(1, 0, 1, 32'h2000_0000, 8'hC3, 32'h0000_AB00, 1'b0, 2'b00, "R4 dma filtered");
        rd_chk(4'd10, 32'h4, "R4 no dma flag");

        // Holdoff merge: data break on B, then fetch breaks on A
        wr(4'd10, 32'h0);
        wr(4'd11, 32'h3);
        wr(4'd0, 32'h3000_0000);
        wr(4'd1, 32'h0);
        wr(4'd3, 32'h37);
        access(0, 0, 1, 32'h2000_0000, 8'hC3, 32'h0000_AB00, 1'b1, 2'b10, "R7 data break");
        access(0, 1, 0, 32'h3000_0000, 8'h5A, 32'h0, 1'b0, 2'b00, "R8 merged fetch 1");
        access(0, 1, 0, 32'h3000_0000, 8'h5A, 32'h0, 1'b0, 2'b00, "R8 merged fetch 2");
        access(0, 1, 0, 32'h3000_0000, 8'h5A, 32'h0, 1'b0, 2'b00, "R8 last held edge");
        access(0, 1, 0, 32'h3000_0000, 8'h5A, 32'h0, 1'b1, 2'b01, "R8 window over fetch break");
        rd_chk(4'd10, 32'h5, "R8 both channel flags set");

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule